// File: doc/BRIEF.md
# Triple Lockstep Output Checker

This block guards the off-chip output of three identical, clocked, deterministic processor replicas running in lockstep. On every clock cycle each replica presents an output word together with a valid flag. The checker compares the three lanes, including the valid flag. A result is forwarded to the external port only when all three lanes are identical and valid in that same cycle. No majority result is ever passed on.

Any difference between the lanes is fatal. The checker latches a sticky fault and forces the external valid low. It also drives a halt request back to the replicas and records which replica disagreed. A 2-of-3 vote is never used to keep going. The fault stays latched until a synchronous clear is applied, after which checking starts again from a clean state.

Top module: `lockstep_guard`

## Requirements
- R1: While reset is asserted and after its release, `out_vld_o`, `fault_o` and `halt_o` are low, `odd_id_o` is 0 and `out_data_o` is all zeros.
- R2: When the three lanes carry identical data with all valid flags high and no fault is latched, the next clock edge loads that data into `out_data_o` and drives `out_vld_o` high for one cycle.
- R3: When the three lanes are identical with all valid flags low, no fault is raised, `out_vld_o` is low and `out_data_o` keeps its previous value.
- R4: Any difference between the lanes, in either data or valid flag, sets `fault_o` at the next clock edge, so it is visible exactly one cycle after the offending inputs. No value is forwarded for that cycle.
- R5: At the first mismatch `odd_id_o` latches the lone disagreeing lane: 1 for lane A, 2 for lane B, 3 for lane C, or 0 when all three lanes differ from each other.
- R6: `fault_o` is sticky. Once set it stays high until `clr_i` is sampled high. Later inputs, agreeing or not, neither change `odd_id_o` nor produce output.
- R7: While `fault_o` is high, `out_vld_o` is low and `out_data_o` does not change.
- R8: `halt_o` rises in the same cycle as `fault_o`, which is one cycle after the mismatch. It stays high for exactly as long as `fault_o` does.
- R9: A cycle with `clr_i` high clears `fault_o`, `halt_o` and `odd_id_o` at the next edge. Lane inputs in that cycle are ignored: no output is produced and no fault is raised. Checking resumes on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous fault clear |
| a_data_i | input | DATA_W | Lane A output word |
| a_vld_i | input | 1 | Lane A valid |
| b_data_i | input | DATA_W | Lane B output word |
| b_vld_i | input | 1 | Lane B valid |
| c_data_i | input | DATA_W | Lane C output word |
| c_vld_i | input | 1 | Lane C valid |
| out_data_o | output | DATA_W | Forwarded word, updated only on agreeing valid cycles |
| out_vld_o | output | 1 | Forwarded word is new this cycle |
| fault_o | output | 1 | Sticky lockstep fault |
| halt_o | output | 1 | Stop request to the replicas |
| odd_id_o | output | 2 | Disagreeing lane at first fault (0 = all differ) |

## Verification
The bench places the disagreeing value in each lane in turn and checks the code latched for each case. A swapped pair compare would report the wrong lane. It also drives a case where all three lanes differ, which a design that simply defaults to a lane would misreport. Lanes that agree on data but not on the valid flag must still fault; a design that compared data alone would forward the word instead. The bench also checks that the first syndrome survives later mismatches, that the output word holds while faulted, and that a clear cycle neither forwards its own inputs nor faults on them.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [1:0] {
    ODD_NONE = 2'd0,
    ODD_A    = 2'd1,
    ODD_B    = 2'd2,
    ODD_C    = 2'd3
  } odd_e;

  localparam int unsigned NUM_LANES = 3;
endpackage

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lockstep_pkg::*;
#(
  parameter int unsigned LANE_W = 33
) (
  input  logic [NUM_LANES-1:0][LANE_W-1:0] lane_i,
  output logic                             agree_o,
  output logic                             any_vld_o,
  output odd_e                             odd_o
);
  localparam int unsigned NUM_PAIRS = 3;

  // pair 0: A/B, pair 1: A/C, pair 2: B/C
  logic [NUM_PAIRS-1:0] eq;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int unsigned LO = (p == 2) ? 1 : 0;
    localparam int unsigned HI = (p == 0) ? 1 : 2;
    assign eq[p] = (lane_i[LO] == lane_i[HI]);
  end

  always_comb begin
    agree_o   = eq[0] & eq[1];
    any_vld_o = lane_i[0][LANE_W-1];
    if (eq[0])      odd_o = ODD_C;
    else if (eq[1]) odd_o = ODD_B;
    else if (eq[2]) odd_o = ODD_A;
    else            odd_o = ODD_NONE;
  end
endmodule

// File: rtl/lockstep_fault.sv
module lockstep_fault
  import lockstep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic mismatch_i,
  input  odd_e odd_i,
  output logic fault_o,
  output logic halt_o,
  output odd_e odd_o
);
  logic fault_d, fault_q;
  logic halt_d, halt_q;
  odd_e odd_d, odd_q;
  logic odd_en;

  always_comb begin
    fault_d = fault_q;
    halt_d  = halt_q;
    odd_d   = odd_q;
    odd_en  = 1'b0;
    if (clr_i) begin
      fault_d = 1'b0;
      halt_d  = 1'b0;
      odd_d   = ODD_NONE;
      odd_en  = 1'b1;
    end else if (!fault_q && mismatch_i) begin
      fault_d = 1'b1;
      halt_d  = 1'b1;
      odd_d   = odd_i;
      odd_en  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      fault_q <= fault_d;
      halt_q  <= halt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     odd_q <= ODD_NONE;
    else if (odd_en) odd_q <= odd_d;
  end

  assign fault_o = fault_q;
  assign halt_o  = halt_q;
  assign odd_o   = odd_q;
endmodule

// File: rtl/lockstep_outreg.sv
module lockstep_outreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] data_q;
  logic              vld_d, vld_q;
  logic              data_en;

  always_comb begin
    data_en = take_i;
    vld_d   = take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/lockstep_guard.sv
module lockstep_guard
  import lockstep_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_vld_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_vld_i,
  input  logic [DATA_W-1:0] c_data_i,
  input  logic              c_vld_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_vld_o,
  output logic              fault_o,
  output logic              halt_o,
  output logic [1:0]        odd_id_o
);
  localparam int unsigned LANE_W = DATA_W + 1;

  logic [NUM_LANES-1:0][LANE_W-1:0] lanes;
  logic agree, any_vld, take, fault;
  odd_e odd_now, odd_held;

  assign lanes[0] = {a_vld_i, a_data_i};
  assign lanes[1] = {b_vld_i, b_data_i};
  assign lanes[2] = {c_vld_i, c_data_i};

  lockstep_cmp #(.LANE_W(LANE_W)) i_cmp (
    .lane_i   (lanes),
    .agree_o  (agree),
    .any_vld_o(any_vld),
    .odd_o    (odd_now)
  );

  lockstep_fault i_fault (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .mismatch_i(!agree),
    .odd_i     (odd_now),
    .fault_o   (fault),
    .halt_o    (halt_o),
    .odd_o     (odd_held)
  );

  assign take = agree & any_vld & ~fault & ~clr_i;

  lockstep_outreg #(.DATA_W(DATA_W)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .data_i(a_data_i),
    .data_o(out_data_o),
    .vld_o (out_vld_o)
  );

  assign fault_o  = fault;
  assign odd_id_o = odd_held;
endmodule

// File: rtl/lockstep_guard_chk.sv
module lockstep_guard_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic [DATA_W-1:0] a_data_i,
  input logic              a_vld_i,
  input logic [DATA_W-1:0] b_data_i,
  input logic              b_vld_i,
  input logic [DATA_W-1:0] c_data_i,
  input logic              c_vld_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_vld_o,
  input logic              fault_o,
  input logic              halt_o,
  input logic [1:0]        odd_id_o
);
  logic same_ab, same_ac;
  assign same_ab = ({a_vld_i, a_data_i} == {b_vld_i, b_data_i});
  assign same_ac = ({a_vld_i, a_data_i} == {c_vld_i, c_data_i});

  assert_fwd_agree_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(same_ab && same_ac && a_vld_i && !clr_i));

  assert_fault_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(!(same_ab && same_ac) && !clr_i));

  assert_odd_c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) && $past(same_ab) |-> odd_id_o == 2'd3);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !clr_i |=> fault_o && $stable(odd_id_o));

  assert_no_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !out_vld_o);

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_data_o) |-> out_vld_o);

  assert_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o == fault_o);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fault_o && !out_vld_o && odd_id_o == 2'd0);
endmodule

bind lockstep_guard lockstep_guard_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_lockstep_guard.sv
`timescale 1ns/1ps
module test_lockstep_guard;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic [W-1:0] ad, bd, cd;
  logic av, bv, cv;
  logic [W-1:0] od;
  logic ov, flt, hlt;
  logic [1:0] odd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lockstep_guard #(.DATA_W(W)) i_lockstep_guard (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .a_data_i(ad), .a_vld_i(av), .b_data_i(bd), .b_vld_i(bv),
    .c_data_i(cd), .c_vld_i(cv),
    .out_data_o(od), .out_vld_o(ov), .fault_o(flt), .halt_o(hlt),
    .odd_id_o(odd)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // apply lane values, let one edge pass, sample 2ns after it
  task automatic step(input logic [W-1:0] a, input logic va,
                      input logic [W-1:0] b, input logic vb,
                      input logic [W-1:0] c, input logic vc, input logic cl);
    ad = a; av = va; bd = b; bv = vb; cd = c; cv = vc; clr = cl;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_state(input string req, input logic e_ov, input logic [W-1:0] e_od,
                              input logic e_flt, input logic [1:0] e_odd);
    chk(req, "out_vld", W'(ov), W'(e_ov));
    chk(req, "out_data", od, e_od);
    chk(req, "fault", W'(flt), W'(e_flt));
    chk(req, "halt", W'(hlt), W'(e_flt));
    chk(req, "odd_id", W'(odd), W'(e_odd));
  endtask

  task automatic do_clear(input logic [W-1:0] held);
    // R9: agreeing valid inputs in the clear cycle are not forwarded
    step(32'hC1EA_0001, 1, 32'hC1EA_0001, 1, 32'hC1EA_0001, 1, 1);
    expect_state("R9", 0, held, 0, 2'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr = 0;
    ad = '0; bd = '0; cd = '0; av = 0; bv = 0; cv = 0;
    #3;
    expect_state("R1", 0, '0, 0, 2'd0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    expect_state("R1", 0, '0, 0, 2'd0);
  endtask

  task automatic t_agree_stream();
    logic [W-1:0] w [3] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0001};
    for (int i = 0; i < 3; i++) begin
      step(w[i], 1, w[i], 1, w[i], 1, 0);
      expect_state("R2", 1, w[i], 0, 2'd0);
    end
  endtask

  task automatic t_idle();
    step(32'hDEAD_0000, 0, 32'hDEAD_0000, 0, 32'hDEAD_0000, 0, 0);
    expect_state("R3", 0, 32'h0000_0001, 0, 2'd0);
  endtask

  task automatic t_odd_lane(input int lane, input logic [1:0] code);
    logic [W-1:0] g = 32'hA5A5_0000 + W'(lane);
    logic [W-1:0] x = g ^ 32'h0100_0000;
    step(g, 1, g, 1, g, 1, 0);
    expect_state("R2", 1, g, 0, 2'd0);
    step(lane == 1 ? x : g, 1, lane == 2 ? x : g, 1, lane == 3 ? x : g, 1, 0);
    expect_state("R4", 0, g, 1, code);
    chk("R5", "odd_id lane", W'(odd), W'(code));
    do_clear(g);
  endtask

  task automatic t_all_differ();
    step(32'h11, 1, 32'h22, 1, 32'h33, 1, 0);
    expect_state("R5", 0, 32'hA5A5_0003, 1, 2'd0);
    do_clear(32'hA5A5_0003);
  endtask

  task automatic t_valid_mismatch();
    step(32'h77, 0, 32'h77, 1, 32'h77, 1, 0);
    expect_state("R4", 0, 32'hA5A5_0003, 1, 2'd1);
    do_clear(32'hA5A5_0003);
  endtask

  task automatic t_sticky();
    step(32'h5000, 1, 32'h5000, 1, 32'h5000, 1, 0);
    expect_state("R2", 1, 32'h5000, 0, 2'd0);
    step(32'h5001, 1, 32'h5001, 1, 32'h5002, 1, 0);
    expect_state("R4", 0, 32'h5000, 1, 2'd3);
    for (int i = 0; i < 3; i++) begin
      step(32'h6000 + W'(i), 1, 32'h6000 + W'(i), 1, 32'h6000 + W'(i), 1, 0);
      expect_state("R7", 0, 32'h5000, 1, 2'd3);
    end
    step(32'h7, 1, 32'h8, 1, 32'h8, 1, 0);
    expect_state("R6", 0, 32'h5000, 1, 2'd3);
    do_clear(32'h5000);
    step(32'h9000, 1, 32'h9000, 1, 32'h9000, 1, 0);
    expect_state("R9", 1, 32'h9000, 0, 2'd0);
  endtask

  task automatic t_clear_ignores_mismatch();
    step(32'h1, 1, 32'h2, 1, 32'h3, 0, 1);
    expect_state("R9", 0, 32'h9000, 0, 2'd0);
    step(32'h4, 1, 32'h4, 1, 32'h4, 1, 0);
    expect_state("R2", 1, 32'h4, 0, 2'd0);
  endtask

  task automatic t_halt_timing();
    // R8: no fault/halt during the offending cycle itself
    ad = 32'hB0; bd = 32'hB1; cd = 32'hB0; av = 1; bv = 1; cv = 1; clr = 0;
    #1;
    chk("R8", "halt before edge", W'(hlt), W'(0));
    @(posedge clk); #2;
    expect_state("R8", 0, 32'h4, 1, 2'd2);
  endtask

  initial begin
    t_reset();
    t_agree_stream();
    t_idle();
    t_odd_lane(1, 2'd1);
    t_odd_lane(2, 2'd2);
    t_odd_lane(3, 2'd3);
    t_all_differ();
    t_valid_mismatch();
    t_sticky();
    t_clear_ignores_mismatch();
    t_halt_timing();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule